// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block listens to the two wires of an I2C bus and runs the addressing part of a slave device. It works from the system clock. Each bus line first passes through a synchronizer. The synchronized lines are then compared with their values one clock earlier, which yields SCL rising and falling edges and the START and STOP bus conditions. A single state machine shifts in the address byte or bytes, compares them with a programmable own address, and pulls SDA low in the acknowledge slot when the address matches. It then reports that the slave is addressed and which way the data will flow.

Both 7-bit and 10-bit own addresses are supported, selected by a mode input. After a successful match the block follows every 8-bit data byte and its acknowledge slot. In write direction it acknowledges each byte. In read direction it stays off the line. This continues until a STOP or a repeated START. A repeated START runs address matching again, and the new R/W bit decides the direction. In 10-bit mode, a slave that was already fully addressed since the last STOP accepts a repeated START with its header byte and R/W=1 as a read request, without a second address byte.

States: `S_IDLE` (ignoring the bus), `S_HDR` (shifting the first byte after START), `S_HDR_ACK` (acknowledge slot of that byte), `S_LOW` (shifting the low byte of a 10-bit address), `S_LOW_ACK`, `S_DATA` (tracking a data byte), `S_DATA_ACK`. Transitions: STOP from any state goes to `S_IDLE`. START or repeated START from any state goes to `S_HDR`. `S_HDR` goes to `S_HDR_ACK` on a 7-bit match, on a matching 10-bit write header, or on a matching 10-bit read header while fully addressed; otherwise it goes to `S_IDLE`. `S_HDR_ACK` goes to `S_DATA` when addressed and to `S_LOW` otherwise. `S_LOW` goes to `S_LOW_ACK` on a match and to `S_IDLE` otherwise. `S_LOW_ACK` goes to `S_DATA`. `S_DATA` and `S_DATA_ACK` alternate.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A falling SDA while SCL is high gives a one-cycle `start_pulse` when the bus is free and a one-cycle `rstart_pulse` when it falls between a START and a STOP. A rising SDA while SCL is high gives a one-cycle `stop_pulse`. At most one of the three is high in any cycle.
- R2: In 7-bit mode (`ten_bit_mode`=0), when bits 7..1 of the first byte after a START (MSB first) equal `own_addr[6:0]`, `sda_oe` goes high after the SCL fall that follows the 8th bit. It drops after the SCL fall that follows the 9th clock. At that point `addressed`=1 and `read_dir` equals bit 0 of the byte (1 = read).
- R3: When the 7-bit address does not match, the block gives no acknowledge and `addressed` stays 0. `sda_oe` stays low through all remaining bytes and slots until the next START or repeated START.
- R4: In 10-bit mode, a first byte of 11110, then `own_addr[9:8]`, then R/W=0 is acknowledged. A following byte equal to `own_addr[7:0]` is acknowledged as well, and the block then sets `addressed`=1 and `read_dir`=0.
- R5: In 10-bit mode, a header whose top five bits or whose two address bits differ, or a second byte that differs, is not acknowledged, and `addressed` stays 0.
- R6: After a match, every data byte in write direction is acknowledged. In read direction `sda_oe` stays low in data bits and in acknowledge slots. `sda_oe` is never high during the eight bits of any byte.
- R7: A repeated START clears `addressed` and `read_dir` and runs address matching again. On a new match, `read_dir` takes the new R/W bit.
- R8: In 10-bit mode, a repeated START followed by a matching header with R/W=1 is acknowledged, and gives `addressed`=1 and `read_dir`=1, but only if the slave was fully addressed since the last STOP. After a STOP, the same header is not acknowledged.
- R9: A STOP clears `addressed` and `read_dir`, releases `sda_oe`, and forgets any earlier full 10-bit addressing.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset, `sda_oe`, `addressed`, `read_dir` and all three pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| own_addr | input | 10 | Own slave address; bits 6..0 used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addressed | output | 1 | Slave selected by the current transfer |
| read_dir | output | 1 | 1 when the master reads from this slave |
| start_pulse | output | 1 | One-cycle pulse on a START |
| rstart_pulse | output | 1 | One-cycle pulse on a repeated START |
| stop_pulse | output | 1 | One-cycle pulse on a STOP |

## Verification
The embedded assertions check on every cycle that the three condition pulses never overlap and that `sda_oe` moves only while the synchronized SCL is low. They also check that it is high only in an acknowledge slot, and never in a read-direction data slot. Further checks are that a rising `addressed` comes with an acknowledge, that a direction is never reported without a selection, and that a STOP clears everything. Whether the right bytes are acknowledged can only be shown by the bench's transfers. The same holds for the 10-bit header and low-byte comparison, the short 10-bit read re-address that depends on history since the last STOP, and the direction change on a repeated START. The bench's transfers mix directed cases with random addresses, modes, directions and transfer lengths.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int TAG_W  = 5;
    localparam logic [TAG_W-1:0] TEN_TAG = 5'b11110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_HDR_ACK,
        S_LOW,
        S_LOW_ACK,
        S_DATA,
        S_DATA_ACK
    } am_state_e;

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    for (genvar i = 0; i < STAGES; i++) begin : g_st
        logic stage;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= RST_VAL;
                else        stage <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage <= RST_VAL;
                else        stage <= g_st[i-1].stage;
            end
        end
    end

    assign q_out = g_st[STAGES-1].stage;

endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic start_p,
    output logic rstart_p,
    output logic stop_p
);

    logic scl_q, sda_q, busy_q;

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            busy_q   <= 1'b0;
            start_p  <= 1'b0;
            rstart_p <= 1'b0;
            stop_p   <= 1'b0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            start_p  <= start_det & ~busy_q;
            rstart_p <= start_det & busy_q;
            stop_p   <= stop_det;
            if (stop_det)       busy_q <= 1'b0;
            else if (start_det) busy_q <= 1'b1;
        end
    end

    // R1: the three condition pulses never coincide
    a_r1_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, rstart_p, stop_p}));

    // R1: a repeated START is reported only inside an open transfer
    a_r1_rstart_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_p |-> busy_q);

    // R1: a STOP always leaves the bus free
    a_r1_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> !busy_q);

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    output logic              sda_oe,
    output logic              addressed,
    output logic              read_dir
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    am_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              oe_q, oe_d;
    logic              addr_q, rd_q, full_q;

    logic in_byte, in_slot, byte_done, slot_end;
    logic m7, m10hdr, m10lo, rw_bit;
    logic take, take_rd, set_full, miss;
    logic enter_ack, ack_val;

    assign in_byte   = state_q inside {S_HDR, S_LOW, S_DATA};
    assign in_slot   = state_q inside {S_HDR_ACK, S_LOW_ACK, S_DATA_ACK};
    assign byte_done = in_byte && (cnt_q == LAST_BIT) && scl_fall;
    assign slot_end  = in_slot && (cnt_q == ONE) && scl_fall;

    assign rw_bit = shreg_q[0];
    assign m7     = shreg_q[BYTE_W-1:1] == own_addr[BYTE_W-2:0];
    assign m10hdr = (shreg_q[BYTE_W-1:BYTE_W-TAG_W] == TEN_TAG) &&
                    (shreg_q[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);
    assign m10lo  = shreg_q == own_addr[BYTE_W-1:0];

    // next-state and decision logic
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        take_rd   = 1'b0;
        set_full  = 1'b0;
        miss      = 1'b0;
        enter_ack = 1'b0;
        ack_val   = 1'b0;
        if (stop_det) begin
            state_d = S_IDLE;
        end else if (start_det) begin
            state_d = S_HDR;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_HDR: begin
                    if (byte_done) begin
                        if (!ten_bit) begin
                            if (m7) begin
                                state_d   = S_HDR_ACK;
                                take      = 1'b1;
                                take_rd   = rw_bit;
                                enter_ack = 1'b1;
                                ack_val   = 1'b1;
                            end else begin
                                state_d = S_IDLE;
                                miss    = 1'b1;
                            end
                        end else if (m10hdr && !rw_bit) begin
                            state_d   = S_HDR_ACK;
                            enter_ack = 1'b1;
                            ack_val   = 1'b1;
                        end else if (m10hdr && rw_bit && full_q) begin
                            state_d   = S_HDR_ACK;
                            take      = 1'b1;
                            take_rd   = 1'b1;
                            enter_ack = 1'b1;
                            ack_val   = 1'b1;
                        end else begin
                            state_d = S_IDLE;
                            miss    = 1'b1;
                        end
                    end
                end
                S_HDR_ACK: begin
                    if (slot_end) state_d = addr_q ? S_DATA : S_LOW;
                end
                S_LOW: begin
                    if (byte_done) begin
                        if (m10lo) begin
                            state_d   = S_LOW_ACK;
                            take      = 1'b1;
                            set_full  = 1'b1;
                            enter_ack = 1'b1;
                            ack_val   = 1'b1;
                        end else begin
                            state_d = S_IDLE;
                            miss    = 1'b1;
                        end
                    end
                end
                S_LOW_ACK: begin
                    if (slot_end) state_d = S_DATA;
                end
                S_DATA: begin
                    if (byte_done) begin
                        state_d   = S_DATA_ACK;
                        enter_ack = 1'b1;
                        ack_val   = !rd_q;
                    end
                end
                S_DATA_ACK: begin
                    if (slot_end) state_d = S_DATA;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        if (stop_det || start_det) oe_d = 1'b0;
        else if (enter_ack)        oe_d = ack_val;
        else if (slot_end)         oe_d = 1'b0;
        else                       oe_d = oe_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            addr_q  <= 1'b0;
            rd_q    <= 1'b0;
            full_q  <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            oe_q <= oe_d;
            if (stop_det || start_det) begin
                addr_q <= 1'b0;
                rd_q   <= 1'b0;
            end else if (take) begin
                addr_q <= 1'b1;
                rd_q   <= take_rd;
            end
            if (stop_det || miss) full_q <= 1'b0;
            else if (set_full)    full_q <= 1'b1;
            if (scl_rise && in_byte)
                shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
            if (stop_det || start_det || (state_d != state_q))
                cnt_q <= '0;
            else if (scl_rise && state_q != S_IDLE && cnt_q != LAST_BIT)
                cnt_q <= cnt_q + ONE;
        end
    end

    assign sda_oe    = oe_q;
    assign addressed = addr_q;
    assign read_dir  = rd_q;

    // R10: the SDA enable only moves while SCL is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !$past(scl_s));

    // R6: the line is pulled only inside an acknowledge slot
    a_r6_oe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> in_slot);

    // R6: read-direction data slots are never driven
    a_r6_read_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA_ACK && rd_q) |-> !oe_q);

    // R2: becoming addressed always comes with an acknowledge
    a_r2_match_acks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_q) |-> oe_q);

    // R7: a direction is only reported for a selected slave
    a_r7_dir_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> addr_q);

    // R9: STOP clears selection, direction and the line drive
    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!addr_q && !rd_q && !oe_q && !full_q));

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_mode,
    output logic              sda_oe,
    output logic              addressed,
    output logic              read_dir,
    output logic              start_pulse,
    output logic              rstart_pulse,
    output logic              stop_pulse
);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2c_am_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (scl_in),
        .q_out (scl_s)
    );

    i2c_am_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sda_in),
        .q_out (sda_s)
    );

    i2c_am_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .start_p   (start_pulse),
        .rstart_p  (rstart_pulse),
        .stop_p    (stop_pulse)
    );

    i2c_am_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .ten_bit   (ten_bit_mode),
        .sda_oe    (sda_oe),
        .addressed (addressed),
        .read_dir  (read_dir)
    );

endmodule

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [9:0] own   = 10'h052;
    logic       ten   = 1'b0;
    logic       sda_line;
    logic       sda_oe, addressed, read_dir, start_pulse, rstart_pulse, stop_pulse;

    assign sda_line = m_sda & ~sda_oe;

    i2c_addr_matcher uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .own_addr     (own),
        .ten_bit_mode (ten),
        .sda_oe       (sda_oe),
        .addressed    (addressed),
        .read_dir     (read_dir),
        .start_pulse  (start_pulse),
        .rstart_pulse (rstart_pulse),
        .stop_pulse   (stop_pulse)
    );

    int n_chk = 0, n_err = 0;
    int cnt_s = 0, cnt_rs = 0, cnt_p = 0;
    int oe_hits = 0, scl_hi_moves = 0;
    bit in_byte = 1'b0;
    bit m_full  = 1'b0;
    logic oe_prev = 1'b0;

    always @(posedge clk) begin
        if (start_pulse)  cnt_s++;
        if (rstart_pulse) cnt_rs++;
        if (stop_pulse)   cnt_p++;
    end

    always @(negedge clk) begin
        if (in_byte && sda_oe) oe_hits++;
        if (rst_n && sda_oe !== oe_prev && m_scl) scl_hi_moves++;
        oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gen_start();
        int s0 = cnt_s, r0 = cnt_rs;
        m_sda = 1'b0; wt(8); m_scl = 1'b0; wt(6);
        chk(cnt_s == s0 + 1 && cnt_rs == r0, "R1 start", cnt_s - s0, 1);
    endtask

    task automatic gen_rstart();
        int s0 = cnt_s, r0 = cnt_rs;
        m_sda = 1'b1; wt(4); m_scl = 1'b1; wt(8);
        m_sda = 1'b0; wt(8); m_scl = 1'b0; wt(6);
        chk(cnt_rs == r0 + 1 && cnt_s == s0, "R1 rstart", cnt_rs - r0, 1);
        chk(addressed == 1'b0 && read_dir == 1'b0, "R7 cleared", {addressed, read_dir}, 0);
    endtask

    task automatic gen_stop();
        int p0 = cnt_p;
        m_sda = 1'b0; wt(4); m_scl = 1'b1; wt(8); m_sda = 1'b1; wt(8);
        chk(cnt_p == p0 + 1, "R1 stop", cnt_p - p0, 1);
        chk({addressed, read_dir, sda_oe} == 3'b000, "R9", {addressed, read_dir, sda_oe}, 0);
        m_full = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        oe_hits = 0;
        for (int i = 0; i < 8; i++) begin
            m_sda = b[7-i];
            wt(4);
            if (i == 0) in_byte = 1'b1;
            m_scl = 1'b1; wt(8);
            m_scl = 1'b0;
            if (i == 7) in_byte = 1'b0;
            wt(4);
        end
        chk(oe_hits == 0, tag, oe_hits, 0);
    endtask

    task automatic ack_slot(output bit acked);
        m_sda = 1'b1; wt(4);
        m_scl = 1'b1; wt(4);
        acked = (sda_line == 1'b0);
        wt(4);
        m_scl = 1'b0; wt(6);
    endtask

    task automatic xfer(input bit rs, input bit rw, input logic [9:0] tgt, input int nb);
        bit match, ack, hdr;
        if (rs) gen_rstart(); else gen_start();
        match = 1'b0;
        if (!ten) begin
            match = (tgt[6:0] == own[6:0]);
            send_byte({tgt[6:0], rw}, "R3 addr byte");
            ack_slot(ack);
            chk(ack == match, match ? "R2 ack" : "R3 nack", ack, match);
            chk({addressed, read_dir} == {match, match & rw}, match ? "R2 flags" : "R3 flags",
                {addressed, read_dir}, {match, match & rw});
        end else begin
            hdr = (tgt[9:8] == own[9:8]);
            send_byte({5'b11110, tgt[9:8], rw}, "R5 hdr byte");
            ack_slot(ack);
            if (!rw) begin
                chk(ack == hdr, hdr ? "R4 hdr ack" : "R5 hdr nack", ack, hdr);
                if (hdr) begin
                    send_byte(tgt[7:0], "R5 low byte");
                    ack_slot(ack);
                    match = (tgt[7:0] == own[7:0]);
                    chk(ack == match, match ? "R4 low ack" : "R5 low nack", ack, match);
                end
                m_full = match;
                chk({addressed, read_dir} == {match, 1'b0}, "R4 flags",
                    {addressed, read_dir}, {match, 1'b0});
            end else begin
                match = hdr && m_full && rs;
                chk(ack == match, "R8 ack", ack, match);
                chk({addressed, read_dir} == {match, match}, "R8 flags",
                    {addressed, read_dir}, {match, match});
                if (!match) m_full = 1'b0;
            end
        end
        for (int k = 0; k < nb; k++) begin
            send_byte(8'($urandom), match ? "R6 data bits" : "R3 quiet");
            ack_slot(ack);
            chk(ack == (match && !rw), "R6 data ack", ack, match && !rw);
        end
    endtask

    initial begin
        bit open;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        wt(5);
        chk({sda_oe, addressed, read_dir, start_pulse, rstart_pulse, stop_pulse} == 6'b0,
            "R11 reset", {sda_oe, addressed, read_dir}, 0);
        rst_n = 1'b1;
        wt(5);
        chk({sda_oe, addressed, read_dir, start_pulse, rstart_pulse, stop_pulse} == 6'b0,
            "R11 after release", {sda_oe, addressed, read_dir}, 0);

        // directed 7-bit cases
        ten = 1'b0; own = 10'h052;
        xfer(1'b0, 1'b0, own, 2); gen_stop();
        xfer(1'b0, 1'b1, own ^ 10'h001, 1); gen_stop();
        xfer(1'b0, 1'b0, own, 1); xfer(1'b1, 1'b1, own, 2); gen_stop();

        // directed 10-bit cases
        ten = 1'b1; own = 10'h2A7;
        xfer(1'b0, 1'b0, own, 1); xfer(1'b1, 1'b1, own, 1); gen_stop();
        xfer(1'b0, 1'b1, own, 0); gen_stop();
        xfer(1'b0, 1'b0, own ^ 10'h100, 1); gen_stop();
        xfer(1'b0, 1'b0, own ^ 10'h004, 1); xfer(1'b1, 1'b1, own, 0); gen_stop();

        // random transfers
        open = 1'b0;
        for (int n = 0; n < 40; n++) begin
            logic [9:0] tgt;
            bit rw;
            int nb, pick;
            if (!open && ($urandom % 4 == 0)) begin
                ten = 1'($urandom);
                own = 10'($urandom);
            end
            pick = int'($urandom % 4);
            case (pick)
                0, 1:    tgt = own;
                2:       tgt = own ^ (10'h001 << ($urandom % 10));
                default: tgt = 10'($urandom);
            endcase
            rw = 1'($urandom);
            nb = int'($urandom % 3);
            xfer(open, rw, tgt, nb);
            if ($urandom % 3 == 0) open = 1'b1;
            else begin gen_stop(); open = 1'b0; end
        end
        if (open) gen_stop();

        chk(scl_hi_moves == 0, "R10 oe with SCL high", scl_hi_moves, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule